// File: doc/BRIEF.md
# Radix-4 Digit-Reversal Output Reorderer

A radix-4 FFT engine with 1024 points emits its results in digit-reversed order: the k-th sample out of the engine belongs to the frequency bin whose index has its five base-4 digits written back to front. This block sits on that output stream. It counts the accepted samples, computes each sample's natural-order bin from that count, and writes the 28-bit I/Q word to that address in one of two storage banks. When a bank holds a whole frame, the block reads it out in address order with its own valid strobe. Meanwhile the next frame fills the other bank.

The mapping swaps whole 2-bit digits and keeps the bit order inside each digit. This differs from the single-bit reversal of a radix-2 engine. The natural-order position of the last accepted sample is also exported as a registered output. A host can use it on its own, for example to tag bins without using the reordered stream.

Top module: `radix4_reorder`

## Requirements
- R1: A 10-bit step counter starts at 0 after reset. It advances by one only on rising edges where `in_valid` is high, and wraps from 1023 to 0. Samples presented while `in_valid` is low are not stored.
- R2: The position of a sample with step count c is the 10-bit value whose bits [9:8] are c[1:0], [7:6] are c[3:2], [5:4] are c[5:4], [3:2] are c[7:6] and [1:0] are c[9:8]. For example, c = 789 (1100010101b) gives 339 (0101010011b).
- R3: `out_pos` is registered. On each edge that accepts a sample, it takes that sample's position. It holds its value on edges where `in_valid` is low.
- R4: The 14 bits of I and the 14 bits of Q pass through unchanged. Only the order of samples within a frame changes.
- R5: The k-th output of a frame (k = 0..1023) carries the input sample whose step count, digit-reversed as in R2, equals k.
- R6: `out_valid` first rises on the second rising edge after the edge that accepts the 1024th sample of a frame. It then stays high for exactly 1024 consecutive cycles per frame, so every low phase of `out_valid` falls on a frame boundary.
- R7: The two banks swap roles each time 1024 samples have been written. Frames presented back to back with no idle cycle come out as one unbroken valid run with no sample lost.
- R8: `busy` is high only while the bank selected for writing is still being read out. It stays low whenever frames arrive no faster than one sample per cycle.
- R9: While `rst_n` is low, `out_valid`, `busy` and `out_pos` are 0. The release of `rst_n` takes effect two clock edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 14 | In-phase part of the input sample |
| in_q | input | 14 | Quadrature part of the input sample |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 14 | In-phase part of the reordered sample |
| out_q | output | 14 | Quadrature part of the reordered sample |
| out_pos | output | 10 | Natural-order position of the last accepted sample |
| busy | output | 1 | Write bank still being read out |

## Verification
The bench tags every sample with its step count and a per-frame code. A design that reversed single bits instead of 2-bit digits, or flipped bits inside a digit, would put the wrong tag at some output position. A counter that advanced on idle cycles would shift every later sample in a frame fed with gaps and would also store the garbage words driven during the gaps. A reader that started one cycle early would emit the last slot before it was written, and two frames fed back to back would break the valid run or lose the frame boundary at the wrap. The exported position is compared after every accepted sample and after every idle cycle, including the worked example 789 to 339.

// File: rtl/rdr_pkg.sv
package rdr_pkg;

  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_e;

  // Base-4 digit reversal of the low 2*digits bits of v.
  function automatic logic [31:0] rdr_digit_rev(input logic [31:0] v, input int unsigned digits);
    logic [31:0] r;
    r = '0;
    for (int unsigned d = 0; d < digits; d++) begin
      r[2*(digits-1-d) +: 2] = v[2*d +: 2];
    end
    return r;
  endfunction

endpackage

// File: rtl/rdr_digit_rev.sv
module rdr_digit_rev #(
  parameter  int DIGITS = 5,
  localparam int AW     = 2 * DIGITS
) (
  input  logic [AW-1:0] idx_i,
  output logic [AW-1:0] rev_o
);

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    assign rev_o[2*(DIGITS-1-d) +: 2] = idx_i[2*d +: 2];
  end

endmodule

// File: rtl/rdr_index_gen.sv
module rdr_index_gen #(
  parameter  int DIGITS = 5,
  localparam int AW     = 2 * DIGITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  output logic [AW-1:0] cnt_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          last_o,
  output logic [AW-1:0] pos_o
);

  logic [AW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] pos_q, pos_d;
  logic [AW-1:0] rev;

  rdr_digit_rev #(.DIGITS(DIGITS)) u_rev (
    .idx_i (cnt_q),
    .rev_o (rev)
  );

  always_comb begin
    cnt_d = cnt_q;
    pos_d = pos_q;
    if (adv_i) begin
      cnt_d = cnt_q + AW'(1);
      pos_d = rev;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pos_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      pos_q <= pos_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign wr_addr_o = rev;
  assign last_o    = (cnt_q == {AW{1'b1}});
  assign pos_o     = pos_q;

endmodule

// File: rtl/rdr_bank.sv
module rdr_bank #(
  parameter  int AW    = 10,
  parameter  int W     = 28,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
    if (re_i) begin
      rdata_q <= mem[raddr_i];
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/rdr_read_ctrl.sv
module rdr_read_ctrl
  import rdr_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  bank_e         start_bank_i,
  output logic          active_o,
  output logic [AW-1:0] addr_o,
  output bank_e         bank_o,
  output logic          valid_o,
  output bank_e         out_bank_o
);

  logic          act_q, act_d;
  logic [AW-1:0] addr_q, addr_d;
  bank_e         bank_q, bank_d;
  logic          vld_q;
  bank_e         obank_q;
  logic          at_end;

  assign at_end = (addr_q == {AW{1'b1}});

  always_comb begin
    act_d  = act_q;
    addr_d = addr_q;
    bank_d = bank_q;
    if (start_i) begin
      act_d  = 1'b1;
      addr_d = '0;
      bank_d = start_bank_i;
    end else if (act_q) begin
      addr_d = addr_q + AW'(1);
      if (at_end) begin
        act_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      addr_q  <= '0;
      bank_q  <= BANK_A;
      vld_q   <= 1'b0;
      obank_q <= BANK_A;
    end else begin
      act_q  <= act_d;
      addr_q <= addr_d;
      bank_q <= bank_d;
      vld_q  <= act_q;
      if (act_q) begin
        obank_q <= bank_q;
      end
    end
  end

  assign active_o   = act_q;
  assign addr_o     = addr_q;
  assign bank_o     = bank_q;
  assign valid_o    = vld_q;
  assign out_bank_o = obank_q;

endmodule

// File: rtl/radix4_reorder.sv
module radix4_reorder
  import rdr_pkg::*;
#(
  parameter  int DIGITS = 5,
  parameter  int DW     = 14,
  localparam int AW     = 2 * DIGITS,
  localparam int WW     = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_i,
  input  logic [DW-1:0] in_q,
  output logic          out_valid,
  output logic [DW-1:0] out_i,
  output logic [DW-1:0] out_q,
  output logic [AW-1:0] out_pos,
  output logic          busy
);

  // reset: asserted asynchronously, released after two edges
  logic rst_s1, rst_s2, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end
  assign rst_int_n = rst_s2;

  logic [AW-1:0] wr_cnt, wr_addr;
  logic          wr_last, frame_done;
  bank_e         wr_bank_q, wr_bank_d;

  rdr_index_gen #(.DIGITS(DIGITS)) u_idx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .adv_i     (in_valid),
    .cnt_o     (wr_cnt),
    .wr_addr_o (wr_addr),
    .last_o    (wr_last),
    .pos_o     (out_pos)
  );

  assign frame_done = in_valid & wr_last;

  always_comb begin
    wr_bank_d = wr_bank_q;
    if (frame_done) begin
      wr_bank_d = (wr_bank_q == BANK_A) ? BANK_B : BANK_A;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      wr_bank_q <= BANK_A;
    end else begin
      wr_bank_q <= wr_bank_d;
    end
  end

  logic          rd_active, rd_valid;
  logic [AW-1:0] rd_addr;
  bank_e         rd_bank, rd_out_bank;

  rdr_read_ctrl #(.AW(AW)) u_rd (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .start_i      (frame_done),
    .start_bank_i (wr_bank_q),
    .active_o     (rd_active),
    .addr_o       (rd_addr),
    .bank_o       (rd_bank),
    .valid_o      (rd_valid),
    .out_bank_o   (rd_out_bank)
  );

  logic [WW-1:0] bank_rdata [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic bank_we, bank_re;
    assign bank_we = in_valid  & (wr_bank_q == bank_e'(b));
    assign bank_re = rd_active & (rd_bank   == bank_e'(b));

    rdr_bank #(.AW(AW), .W(WW)) u_mem (
      .clk     (clk),
      .we_i    (bank_we),
      .waddr_i (wr_addr),
      .wdata_i ({in_i, in_q}),
      .re_i    (bank_re),
      .raddr_i (rd_addr),
      .rdata_o (bank_rdata[b])
    );
  end

  logic [WW-1:0] sel_word;
  assign sel_word  = (rd_out_bank == BANK_B) ? bank_rdata[1] : bank_rdata[0];
  assign out_i     = sel_word[WW-1:DW];
  assign out_q     = sel_word[DW-1:0];
  assign out_valid = rd_valid;
  assign busy      = rd_active & (rd_bank == wr_bank_q);

endmodule

// File: rtl/radix4_reorder_chk.sv
module radix4_reorder_chk
  import rdr_pkg::*;
#(
  parameter  int DIGITS = 5,
  localparam int AW     = 2 * DIGITS
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [AW-1:0] wr_cnt,
  input logic [AW-1:0] out_pos,
  input logic          out_valid,
  input logic          frame_done,
  input logic          wr_bank
);

  logic [AW-1:0] vcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt <= '0;
    end else if (out_valid) begin
      vcnt <= vcnt + AW'(1);
    end
  end

  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> wr_cnt == $past(wr_cnt) + AW'(1));

  p_pos_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_pos == AW'(rdr_digit_rev(32'($past(wr_cnt)), DIGITS)));

  p_pos_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_pos));

  p_frame_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(frame_done, 2));

  p_whole_frames_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> vcnt == '0);

  p_bank_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> wr_bank != $past(wr_bank));

endmodule

bind radix4_reorder radix4_reorder_chk #(.DIGITS(DIGITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .in_valid   (in_valid),
  .wr_cnt     (wr_cnt),
  .out_pos    (out_pos),
  .out_valid  (out_valid),
  .frame_done (frame_done),
  .wr_bank    (wr_bank_q)
);

// File: tb/radix4_reorder_tb.sv
module radix4_reorder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DIGITS     = 5;
  localparam int AW         = 2 * DIGITS;
  localparam int N          = 1 << AW;
  localparam int DW         = 14;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [DW-1:0] in_i, in_q;
  logic          out_valid, busy;
  logic [DW-1:0] out_i, out_q;
  logic [AW-1:0] out_pos;

  always #(CLK_PERIOD/2) clk = ~clk;

  radix4_reorder u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_i      (in_i),
    .in_q      (in_q),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q),
    .out_pos   (out_pos),
    .busy      (busy)
  );

  int checks = 0;
  int errors = 0;
  logic [2*DW-1:0] exp_fifo [$];
  bit   mon_en = 1'b0;
  bit   busy_seen = 1'b0;
  int   outs_seen = 0;
  int   run_len = 0;
  int   max_run = 0;
  bit   done = 1'b0;

  function automatic int rev4(input int v);
    int r = 0;
    for (int d = 0; d < DIGITS; d++) r = (r << 2) | ((v >> (2*d)) & 3);
    return r;
  endfunction

  function automatic logic [DW-1:0] qtag(input int j, input int tag);
    return DW'((j * 7 + tag * 1000) ^ 'h2A5A);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver: R1 R2 R3 on the position port, pushes expected output order (R5)
  task automatic send_frame(input int tag, input bit gaps);
    for (int j = 0; j < N; j++) begin
      if (gaps && (j % 5) == 2) begin
        in_valid = 1'b0;
        in_i = '1;
        in_q = '1;
        @(negedge clk);
        chk(out_pos == AW'(rev4(j - 1)), "R3", "position held on idle edge", int'(out_pos), rev4(j - 1));
      end
      in_valid = 1'b1;
      in_i = DW'(j);
      in_q = qtag(j, tag);
      if (j == N - 1) begin
        for (int k = 0; k < N; k++) exp_fifo.push_back({DW'(rev4(k)), qtag(rev4(k), tag)});
      end
      @(negedge clk);
      if (j == 789)
        chk(out_pos == AW'(339), "R2", "digit reversal of 789", int'(out_pos), 339);
      else
        chk(out_pos == AW'(rev4(j)), "R1", "position of step count", int'(out_pos), rev4(j));
    end
  endtask

  // monitor: R4 R5 R6 R8
  always @(negedge clk) begin
    if (mon_en) begin
      if (busy) busy_seen = 1'b1;
      if (out_valid) begin
        run_len++;
        outs_seen++;
        if (exp_fifo.size() == 0) begin
          chk(1'b0, "R6", "output before frame complete", outs_seen, 0);
        end else begin
          logic [2*DW-1:0] e;
          e = exp_fifo.pop_front();
          chk(out_i == e[2*DW-1:DW], "R5", "I of reordered sample", int'(out_i), int'(e[2*DW-1:DW]));
          chk(out_q == e[DW-1:0], "R4", "Q of reordered sample", int'(out_q), int'(e[DW-1:0]));
        end
      end else if (run_len != 0) begin
        chk((run_len % N) == 0, "R6", "valid run length multiple of frame", run_len, N);
        if (run_len > max_run) max_run = run_len;
        run_len = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_i = '0;
    in_q = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid in reset", int'(out_valid), 0);
    chk(busy == 1'b0, "R9", "busy in reset", int'(busy), 0);
    chk(out_pos == '0, "R9", "out_pos in reset", int'(out_pos), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1'b1;

    send_frame(1, 1'b0);
    send_frame(2, 1'b0);  // back to back: R7
    in_valid = 1'b0;
    repeat (40) @(negedge clk);
    send_frame(3, 1'b1);  // idle gaps: R1 R3
    in_valid = 1'b0;
    repeat (N + 20) @(negedge clk);

    chk(outs_seen == 3 * N, "R7", "total samples out", outs_seen, 3 * N);
    chk(exp_fifo.size() == 0, "R5", "expected samples left", exp_fifo.size(), 0);
    chk(max_run >= 2 * N, "R7", "unbroken run for back-to-back frames", max_run, 2 * N);
    chk(busy_seen == 1'b0, "R8", "busy while streaming", int'(busy_seen), 0);
    chk(out_valid == 1'b0, "R6", "valid low after last frame", int'(out_valid), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule